// File: doc/BRIEF.md
# Binarized Three-Layer Classifier Core

This block classifies a 16-bit vector of binary features into one of three trading decisions (hold, buy or sell) using a binarized neural network with 16 inputs, 64 hidden neurons and 3 output neurons. Every weight and activation is a single bit standing for +1 or -1. A product is therefore the XNOR of two bits, and a sum is the count of ones among those XNOR results. The block has no multipliers.

A host first loads the 1216 weight bits one at a time through a bit-addressed write port. It may also load a per-neuron threshold for each hidden neuron. It then presents a feature word together with a one-cycle start strobe. Neuron evaluation is spread over a fixed schedule, so every inference takes the same number of clock cycles whatever the data. The schedule is: one cycle to capture the features, sixteen cycles evaluating four hidden neurons each, four cycles accumulating sixteen hidden bits into each of the three output scores, one cycle to pick the winner, and one cycle to publish it. The result is a 2-bit class code with a one-cycle done strobe.

Top module: `bnn_infer_core`

## Requirements
- R1: After reset, `done` is 0 and `cls` is 00. All weight bits are 0 and every hidden threshold is 8.
- R2: A write with `wr_en` to a bit address below 1024 sets hidden weight (neuron*16 + feature). An address from 1024 to 1215 sets output weight (class*64 + hidden), where class uses the output code of R4. Addresses from 1216 up change nothing.
- R3: Hidden neuron n is 1 when the number of agreeing bits between the feature word and its 16 weights (XNOR, then count the ones) is at least its threshold. Otherwise it is 0.
- R4: Each class score is the count of ones in the XNOR of the 64 hidden bits with that class's 64 weights. `cls` reports the class with the highest score, coded 00 = HOLD, 01 = BUY, 10 = SELL.
- R5: On equal top scores, HOLD is preferred over BUY, and BUY is preferred over SELL.
- R6: When `start` is sampled high while idle, `done` pulses high for exactly one cycle, and `cls` takes its new value. Both happen on the 22nd rising edge after the sampling edge, so the operation spans 23 edges. `cls` then holds until the next result.
- R7: A `start` strobe sampled while an inference is in progress is ignored. The running result is unchanged and no extra result is produced.
- R8: Weight writes and threshold writes presented while an inference is in progress are ignored. They do not affect the running inference or any later one.
- R9: A write with `thr_wr_en` sets the threshold of hidden neuron `thr_idx` to `thr_val`.
- R10: `cls` never carries the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to classify `feat` |
| feat | input | 16 | Binary feature word |
| wr_en | input | 1 | Weight bit write strobe |
| wr_addr | input | 11 | Weight bit address |
| wr_bit | input | 1 | Weight bit value (1 = +1, 0 = -1) |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_idx | input | 6 | Hidden neuron whose threshold is written |
| thr_val | input | 5 | New threshold (0 to 16) |
| done | output | 1 | One-cycle strobe with a new result |
| cls | output | 2 | Class code: 00 HOLD, 01 BUY, 10 SELL |

## Verification
Hand-built weight sets force every hidden bit to 1. This pins the output scores to chosen values, which separates the tie order (three-way ties, and BUY against SELL) from the plain argmax. The same setup makes a single blocked weight write or threshold write flip the class, so a write that leaks in during a run shows up at the output. Random weights and thresholds, driven with random feature words plus all-zero and all-ones words, exercise the XNOR counting, the threshold compare and the weight address mapping against a bench model. A second start strobe in mid-run shows whether the captured features or the schedule can be disturbed.

// File: rtl/bnn_pkg.sv
package bnn_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HID,
      PH_OUT,
      PH_ARG,
      PH_RES
   } phase_t;

   localparam logic [1:0] CODE_HOLD = 2'b00;
   localparam logic [1:0] CODE_BUY  = 2'b01;
   localparam logic [1:0] CODE_SELL = 2'b10;
endpackage

// File: rtl/bnn_weight_store.sv
module bnn_weight_store #(
   parameter int N_IN     = 16,
   parameter int N_HID    = 64,
   parameter int N_OUT    = 3,
   parameter int THR_INIT = 8,
   localparam int HID_BITS = N_IN * N_HID,
   localparam int OUT_BITS = N_HID * N_OUT,
   localparam int ADDR_W   = $clog2(HID_BITS + OUT_BITS),
   localparam int THR_W    = $clog2(N_IN + 1),
   localparam int NI_W     = $clog2(N_HID)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lock,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic                wr_bit,
   input  logic                thr_wr_en,
   input  logic [NI_W-1:0]     thr_idx,
   input  logic [THR_W-1:0]    thr_val,
   output logic [HID_BITS-1:0] hid_w,
   output logic [OUT_BITS-1:0] out_w,
   output logic [THR_W-1:0]    thr [N_HID]
);
   localparam int HID_IW = $clog2(HID_BITS);
   localparam int OUT_IW = $clog2(OUT_BITS);

   logic [HID_IW-1:0] hid_idx;
   logic [OUT_IW-1:0] out_idx;
   logic [ADDR_W-1:0] out_off;

   assign hid_idx = wr_addr[HID_IW-1:0];
   assign out_off = wr_addr - ADDR_W'(HID_BITS);
   assign out_idx = out_off[OUT_IW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hid_w <= '0;
         out_w <= '0;
         for (int i = 0; i < N_HID; i++) thr[i] <= THR_W'(THR_INIT);
      end else if (!lock) begin
         if (wr_en) begin
            if (int'(wr_addr) < HID_BITS)
               hid_w[hid_idx] <= wr_bit;
            else if (int'(wr_addr) < HID_BITS + OUT_BITS)
               out_w[out_idx] <= wr_bit;
         end
         if (thr_wr_en) thr[thr_idx] <= thr_val;
      end
   end

   // A blocked weight write must leave both weight arrays untouched
   assert_locked_weights_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && wr_en) |=> ($stable(hid_w) && $stable(out_w)));
endmodule

// File: rtl/bnn_hidden_lanes.sv
module bnn_hidden_lanes #(
   parameter int N_IN   = 16,
   parameter int N_HID  = 64,
   parameter int LANES  = 4,
   parameter int STEP_W = 4,
   localparam int THR_W = $clog2(N_IN + 1),
   localparam int NI_W  = $clog2(N_HID)
) (
   input  logic [N_IN-1:0]       x,
   input  logic [STEP_W-1:0]     step,
   input  logic [N_IN*N_HID-1:0] hid_w,
   input  logic [THR_W-1:0]      thr [N_HID],
   output logic [LANES-1:0]      bits
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [NI_W-1:0]  nidx;
      logic [N_IN-1:0]  agree;
      logic [THR_W-1:0] pop;

      always_comb begin
         nidx  = NI_W'(int'(step) * LANES + l);
         agree = ~(x ^ hid_w[int'(nidx) * N_IN +: N_IN]);
         pop   = '0;
         for (int b = 0; b < N_IN; b++) pop = pop + THR_W'(agree[b]);
      end

      assign bits[l] = (pop >= thr[nidx]);
   end
endmodule

// File: rtl/bnn_out_accum.sv
module bnn_out_accum #(
   parameter int N_HID     = 64,
   parameter int N_OUT     = 3,
   parameter int OUT_CHUNK = 16,
   parameter int STEP_W    = 4,
   localparam int CP_W     = $clog2(OUT_CHUNK + 1)
) (
   input  logic [N_HID-1:0]       hid,
   input  logic [N_HID*N_OUT-1:0] out_w,
   input  logic [STEP_W-1:0]      chunk,
   output logic [CP_W-1:0]        part [N_OUT]
);
   for (genvar j = 0; j < N_OUT; j++) begin : g_class
      logic [OUT_CHUNK-1:0] agree;
      always_comb begin
         agree = ~(hid[int'(chunk) * OUT_CHUNK +: OUT_CHUNK]
                 ^ out_w[j * N_HID + int'(chunk) * OUT_CHUNK +: OUT_CHUNK]);
         part[j] = '0;
         for (int b = 0; b < OUT_CHUNK; b++) part[j] = part[j] + CP_W'(agree[b]);
      end
   end
endmodule

// File: rtl/bnn_infer_core.sv
module bnn_infer_core #(
   parameter int N_IN      = 16,
   parameter int N_HID     = 64,
   parameter int N_OUT     = 3,
   parameter int HID_LANES = 4,
   parameter int OUT_CHUNK = 16,
   parameter int THR_INIT  = 8,
   localparam int ADDR_W   = $clog2(N_IN * N_HID + N_HID * N_OUT),
   localparam int THR_W    = $clog2(N_IN + 1),
   localparam int NI_W     = $clog2(N_HID),
   localparam int CLS_W    = $clog2(N_OUT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [N_IN-1:0]   feat,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_bit,
   input  logic              thr_wr_en,
   input  logic [NI_W-1:0]   thr_idx,
   input  logic [THR_W-1:0]  thr_val,
   output logic              done,
   output logic [CLS_W-1:0]  cls
);
   import bnn_pkg::*;

   localparam int HID_STEPS = N_HID / HID_LANES;
   localparam int OUT_STEPS = N_HID / OUT_CHUNK;
   localparam int MAX_STEPS = (HID_STEPS > OUT_STEPS) ? HID_STEPS : OUT_STEPS;
   localparam int STEP_W    = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;
   localparam int LATENCY   = 1 + HID_STEPS + OUT_STEPS + 2;
   localparam int LAT_W     = $clog2(LATENCY + 1);
   localparam int SC_W      = $clog2(N_HID + 1);
   localparam int CP_W      = $clog2(OUT_CHUNK + 1);

   if (N_HID % HID_LANES != 0) begin : g_bad_lanes
      $error("N_HID must be a multiple of HID_LANES");
   end
   if (N_HID % OUT_CHUNK != 0) begin : g_bad_chunk
      $error("N_HID must be a multiple of OUT_CHUNK");
   end
   if (THR_INIT > N_IN) begin : g_bad_thr
      $error("THR_INIT must not exceed N_IN");
   end

   phase_t               phase_q;
   logic [STEP_W-1:0]    step_q;
   logic [N_IN-1:0]      x_q;
   logic [N_HID-1:0]     hid_q;
   logic [SC_W-1:0]      score_q [N_OUT];
   logic [CLS_W-1:0]     win_q;
   logic [CLS_W-1:0]     cls_q;
   logic                 done_q;
   logic                 busy;
   logic [N_IN*N_HID-1:0]  hid_w;
   logic [N_HID*N_OUT-1:0] out_w;
   logic [THR_W-1:0]     thr [N_HID];
   logic [HID_LANES-1:0] lane_bits;
   logic [CP_W-1:0]      part [N_OUT];
   logic [CLS_W-1:0]     best;

   assign busy = (phase_q != PH_IDLE);

   bnn_weight_store #(.N_IN(N_IN), .N_HID(N_HID), .N_OUT(N_OUT), .THR_INIT(THR_INIT)) u_store (
      .clk(clk), .rst_n(rst_n), .lock(busy),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
      .thr_wr_en(thr_wr_en), .thr_idx(thr_idx), .thr_val(thr_val),
      .hid_w(hid_w), .out_w(out_w), .thr(thr)
   );

   bnn_hidden_lanes #(.N_IN(N_IN), .N_HID(N_HID), .LANES(HID_LANES), .STEP_W(STEP_W)) u_lanes (
      .x(x_q), .step(step_q), .hid_w(hid_w), .thr(thr), .bits(lane_bits)
   );

   bnn_out_accum #(.N_HID(N_HID), .N_OUT(N_OUT), .OUT_CHUNK(OUT_CHUNK), .STEP_W(STEP_W)) u_accum (
      .hid(hid_q), .out_w(out_w), .chunk(step_q), .part(part)
   );

   // Lowest index wins on equal scores: strict compare while scanning upward
   always_comb begin
      best = '0;
      for (int j = 1; j < N_OUT; j++)
         if (score_q[j] > score_q[best]) best = CLS_W'(j);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         step_q  <= '0;
         x_q     <= '0;
         hid_q   <= '0;
         win_q   <= '0;
         cls_q   <= '0;
         done_q  <= 1'b0;
         for (int j = 0; j < N_OUT; j++) score_q[j] <= '0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            PH_IDLE: if (start) begin
               x_q     <= feat;
               step_q  <= '0;
               phase_q <= PH_HID;
               for (int j = 0; j < N_OUT; j++) score_q[j] <= '0;
            end
            PH_HID: begin
               hid_q[int'(step_q) * HID_LANES +: HID_LANES] <= lane_bits;
               if (step_q == STEP_W'(HID_STEPS - 1)) begin
                  step_q  <= '0;
                  phase_q <= PH_OUT;
               end else step_q <= step_q + 1'b1;
            end
            PH_OUT: begin
               for (int j = 0; j < N_OUT; j++) score_q[j] <= score_q[j] + SC_W'(part[j]);
               if (step_q == STEP_W'(OUT_STEPS - 1)) phase_q <= PH_ARG;
               else step_q <= step_q + 1'b1;
            end
            PH_ARG: begin
               win_q   <= best;
               phase_q <= PH_RES;
            end
            PH_RES: begin
               cls_q   <= win_q;
               done_q  <= 1'b1;
               phase_q <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign done = done_q;
   assign cls  = cls_q;

   // Checker state: edges since the accepting edge
   logic [LAT_W-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= '0;
      else if (!busy && start) lat_q <= '0;
      else if (busy) lat_q <= lat_q + 1'b1;
   end

   logic win_max, win_order;
   always_comb begin
      win_max   = 1'b1;
      win_order = 1'b1;
      for (int j = 0; j < N_OUT; j++) begin
         if (score_q[j] > score_q[win_q]) win_max = 1'b0;
         if (j < int'(win_q) && score_q[j] == score_q[win_q]) win_order = 1'b0;
      end
   end

   assert_fixed_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == LAT_W'(LATENCY - 1)));
   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_valid_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(cls) < N_OUT));
   assert_winner_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RES) |-> win_max);
   assert_tie_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RES) |-> win_order);
   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(x_q));
endmodule

// File: tb/tb_bnn_infer_core.sv
`timescale 1ns/1ps
module tb_bnn_infer_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] feat = '0;
   logic        wr_en = 1'b0;
   logic [10:0] wr_addr = '0;
   logic        wr_bit = 1'b0;
   logic        thr_wr_en = 1'b0;
   logic [5:0]  thr_idx = '0;
   logic [4:0]  thr_val = '0;
   logic        done;
   logic [1:0]  cls;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic [15:0] m_hid [64];
   logic [63:0] m_out [3];
   int          m_thr [64];

   always #4 clk = ~clk;

   bnn_infer_core dut (
      .clk(clk), .rst_n(rst_n), .start(start), .feat(feat),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
      .thr_wr_en(thr_wr_en), .thr_idx(thr_idx), .thr_val(thr_val),
      .done(done), .cls(cls)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic logic [1:0] model(input logic [15:0] x);
      logic [63:0] h;
      int sc [3];
      int bi;
      for (int n = 0; n < 64; n++) begin
         int c = 0;
         for (int b = 0; b < 16; b++) c += (x[b] == m_hid[n][b]) ? 1 : 0;
         h[n] = (c >= m_thr[n]);
      end
      for (int k = 0; k < 3; k++) begin
         sc[k] = 0;
         for (int b = 0; b < 64; b++) sc[k] += (h[b] == m_out[k][b]) ? 1 : 0;
      end
      bi = 0;
      for (int k = 1; k < 3; k++) if (sc[k] > sc[bi]) bi = k;
      return 2'(bi);
   endfunction

   task automatic wr_w(input int addr, input logic b);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 11'(addr); wr_bit = b;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      if (addr < 1024) m_hid[addr / 16][addr % 16] = b;
      else if (addr < 1216) m_out[(addr - 1024) / 64][(addr - 1024) % 64] = b;
   endtask

   task automatic wr_t(input int idx, input int v);
      @(negedge clk);
      thr_wr_en = 1'b1; thr_idx = 6'(idx); thr_val = 5'(v);
      @(posedge clk);
      @(negedge clk);
      thr_wr_en = 1'b0;
      m_thr[idx] = v;
   endtask

   // mode 0 plain, 1 second start mid-run, 2 weight write mid-run, 3 threshold write mid-run
   task automatic run(input logic [15:0] x, input int mode, input string req);
      logic [1:0] expc;
      bit quiet;
      expc = model(x);
      @(negedge clk);
      start = 1'b1; feat = x;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      quiet = 1;
      for (int cyc = 1; cyc <= 21; cyc++) begin
         @(posedge clk);
         @(negedge clk);
         if (done) quiet = 0;
         if (cyc == 5) begin
            if (mode == 1) begin start = 1'b1; feat = ~x; end
            if (mode == 2) begin wr_en = 1'b1; wr_addr = 11'(1024 + 128); wr_bit = 1'b1; end
            if (mode == 3) begin thr_wr_en = 1'b1; thr_idx = 6'd0; thr_val = 5'd17; end
         end
         if (cyc == 6) begin start = 1'b0; wr_en = 1'b0; thr_wr_en = 1'b0; end
      end
      chk(quiet, "R6 done early", 1, 0);
      @(posedge clk);
      @(negedge clk);
      chk(done === 1'b1, "R6 done at edge 22", int'(done), 1);
      chk(cls === expc, req, int'(cls), int'(expc));
      chk(cls !== 2'b11, "R10 code 11", int'(cls), 0);
      @(posedge clk);
      @(negedge clk);
      chk(done === 1'b0, "R6 done one cycle", int'(done), 0);
      chk(cls === expc, "R6 cls held", int'(cls), int'(expc));
      if (mode == 1) begin
         quiet = 1;
         for (int i = 0; i < 24; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) quiet = 0;
         end
         chk(quiet, "R7 no second result", 0, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog act=1 exp=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1f3a));
      for (int n = 0; n < 64; n++) begin m_hid[n] = '0; m_thr[n] = 8; end
      for (int k = 0; k < 3; k++) m_out[k] = '0;
      repeat (3) @(negedge clk);
      chk(done === 1'b0, "R1 done after reset", int'(done), 0);
      chk(cls === 2'b00, "R1 cls after reset", int'(cls), 0);
      rst_n = 1'b1;
      run(16'h00ff, 0, "R1 reset weights give HOLD");
      run(16'h1234, 0, "R1 reset thresholds");

      // All hidden bits forced to 1 by zero thresholds
      for (int n = 0; n < 64; n++) wr_t(n, 0);
      run(16'hA5A5, 0, "R5 three-way tie HOLD");
      run(16'hA5A5, 2, "R8 weight write in run ignored");
      run(16'h5A5A, 0, "R8 weight write stayed out");
      wr_w(1024 + 128, 1'b1);
      run(16'h0001, 0, "R2 output weight address SELL");
      run(16'h0002, 3, "R8 threshold write in run ignored");
      run(16'h0003, 0, "R8 threshold write stayed out");
      wr_t(0, 17);
      run(16'h0004, 0, "R9 threshold write moves class");
      wr_t(0, 0);
      wr_w(1024 + 64, 1'b1);
      run(16'h0005, 0, "R5 BUY over SELL on tie");
      wr_w(1300, 1'b1);
      run(16'h0006, 0, "R2 address above range ignored");

      // Random weights and thresholds
      for (int a = 0; a < 1216; a++) wr_w(a, 1'($urandom % 2));
      for (int n = 0; n < 64; n++) wr_t(n, 4 + int'($urandom % 9));
      run(16'h0000, 0, "R3 all-zero features");
      run(16'hffff, 0, "R3 all-one features");
      run(16'($urandom), 1, "R7 start in run ignored");
      for (int i = 0; i < 30; i++) run(16'($urandom), 0, "R4 random argmax");
      for (int a = 0; a < 1216; a++) wr_w(a, 1'($urandom % 4 == 0));
      for (int i = 0; i < 15; i++) run(16'($urandom), 0, "R3 sparse weights");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule